// File: doc/BRIEF.md
# Ring Trip / Loop Closure Detector

This block watches a signed line measurement, one sample per strobe, and decides whether the subscriber loop has closed or whether a ring trip has happened. Each valid sample first passes through a first-order digital low-pass filter. The filter removes the AC content, such as ringing voltage riding on the measurement. Two filter coefficients are held at the ports, one for loop-closure sensing and one for ring-trip sensing, and a select input picks which one is applied.

The filtered value is compared against a programmable signed threshold. The result of that compare is exposed directly as a raw detect bit. It also feeds a debounce stage, and the reported status moves to the new value only after the compare has held that value for a programmable number of consecutive samples. Every change of the debounced status raises a pending flag. Writing 1 clears the flag, and an enable gates it onto the interrupt line. The analog sensing and the converter that produces the samples sit outside this block.

Top module: `line_state_detector`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `filt_out`, `raw_det`, `det_status`, `irq_pending` and `irq` are all 0, and the debounce length register holds 10.
- R2: On each clock edge with `smp_valid`=1, the filter state becomes y + floor((x − y)·k / 2^15), saturated to the signed 16-bit range [−32768, 32767]. Here x is `smp`, y is the previous state and k is the selected signed 16-bit coefficient. The state is visible on `filt_out`.
- R3: `sel_ring`=1 selects `coef_ring` as k, and `sel_ring`=0 selects `coef_loop`.
- R4: On each valid sample, `raw_det` becomes 1 when the new filter state is strictly greater than the signed `thresh`, and 0 otherwise.
- R5: A clock edge with `smp_valid`=0 leaves `filt_out`, `raw_det`, `det_status` and the debounce count unchanged.
- R6: `det_status` takes the compare value on the valid sample that completes N consecutive valid samples whose compare value differs from `det_status`. N is the debounce length, and a length of 0 behaves as 1. A valid sample whose compare equals `det_status` restarts the count.
- R7: A pulse on `deb_load` stores the 7-bit `deb_len` as the debounce length, and that length applies from the next valid sample onward.
- R8: `irq_pending` is set on the edge where `det_status` changes. It is cleared on an edge with `irq_clr`=1, and when a set and a clear fall on the same edge, the set wins.
- R9: `irq` equals `irq_pending` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe; one debounce tick |
| smp | input | 16 | Signed line measurement |
| sel_ring | input | 1 | 1: ring-trip coefficient, 0: loop-closure coefficient |
| coef_loop | input | 16 | Signed filter coefficient for loop closure, 1.15 fraction |
| coef_ring | input | 16 | Signed filter coefficient for ring trip, 1.15 fraction |
| thresh | input | 16 | Signed detect threshold |
| deb_load | input | 1 | Load strobe for the debounce length |
| deb_len | input | 7 | Debounce length in samples |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Write-1 clear of the pending flag |
| filt_out | output | 16 | Filter state |
| raw_det | output | 1 | Unfiltered compare result |
| det_status | output | 1 | Debounced detect status |
| irq_pending | output | 1 | Status-change pending flag |
| irq | output | 1 | Masked interrupt |

## Verification
Directed steps from a zeroed filter state pin down the two coefficient paths and the rounding of the fractional multiply. Steps with extreme inputs and a negative coefficient push the sum past both rails, which separates saturation from wraparound. Runs of samples above and below the threshold, with single-sample glitches and gaps in the strobe, distinguish a consecutive-sample debounce from a cumulative one, and show the default length of 10 against the loaded lengths 0 and 3. A long random run varies the sample, both coefficients, the threshold, the length, the strobe, the clear and the enable together, and a bench model of the requirements tracks every output on every cycle.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  // coefficient selection for the shared filter
  typedef enum logic {
    SEL_LOOP = 1'b0,
    SEL_RING = 1'b1
  } det_sel_e;

  localparam int unsigned LSD_DBW      = 7;
  localparam int unsigned LSD_DB_RESET = 10;
endpackage

// File: rtl/lsd_lowpass.sv
module lsd_lowpass #(
  parameter int unsigned W    = 16,
  parameter int unsigned FRAC = 15
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp,
  input  logic signed [W-1:0] coef,
  output logic signed [W-1:0] y_q,
  output logic signed [W-1:0] y_nxt
);
  localparam int unsigned PW = 2*W + 1;
  localparam logic signed [PW-1:0] MAXV = PW'((2**(W-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(1);

  logic signed [PW-1:0] smp_e, y_e, coef_e, diff_e, prod_e, sum_e;

  always_comb begin
    smp_e  = {{(W+1){smp[W-1]}}, smp};
    y_e    = {{(W+1){y_q[W-1]}}, y_q};
    coef_e = {{(W+1){coef[W-1]}}, coef};
    diff_e = smp_e - y_e;
    prod_e = diff_e * coef_e;
    sum_e  = (prod_e >>> FRAC) + y_e;
    if (sum_e > MAXV)      y_nxt = MAXV[W-1:0];
    else if (sum_e < MINV) y_nxt = MINV[W-1:0];
    else                   y_nxt = sum_e[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)            y_q <= '0;
    else if (smp_valid) y_q <= y_nxt;
  end

  AST_FILT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(y_q)); // R5
endmodule

// File: rtl/lsd_debounce.sv
module lsd_debounce #(
  parameter int unsigned W      = 16,
  parameter int unsigned DBW    = lsd_pkg::LSD_DBW,
  parameter int unsigned DB_RST = lsd_pkg::LSD_DB_RESET
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic signed [W-1:0] filt_nxt,
  input  logic signed [W-1:0] thresh,
  input  logic                deb_load,
  input  logic [DBW-1:0]      deb_len,
  output logic                raw_q,
  output logic                det_q,
  output logic                det_chg
);
  logic [DBW-1:0] len_q, cnt_q, len_eff;
  logic [DBW:0]   cnt_inc;
  logic           cmp, differ, flip;

  always_comb begin
    len_eff = (len_q == '0) ? DBW'(1) : len_q;
    cmp     = filt_nxt > thresh;
    differ  = cmp != det_q;
    cnt_inc = {1'b0, cnt_q} + (DBW+1)'(1);
    flip    = step && differ && (cnt_inc >= {1'b0, len_eff});
    det_chg = flip;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= DBW'(DB_RST);
      raw_q <= 1'b0;
      det_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (deb_load) len_q <= deb_len;
      if (step) begin
        raw_q <= cmp;
        if (!differ) begin
          cnt_q <= '0;
        end else if (flip) begin
          det_q <= cmp;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_inc[DBW-1:0];
        end
      end
    end
  end

  AST_DET_TAKES_RAW: assert property (@(posedge clk) disable iff (rst)
    (det_q != $past(det_q)) |-> (det_q == raw_q)); // R6
  AST_IDLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    (det_q == raw_q) |-> (cnt_q == '0)); // R6
  AST_DET_HOLD: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(det_q) && $stable(raw_q))); // R5
endmodule

// File: rtl/lsd_irq.sv
module lsd_irq #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic pend_q,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst)      pend_q <= 1'b0;
    else if (set) pend_q <= 1'b1;
    else if (clr) pend_q <= 1'b0;
  end

  generate
    if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= pend_q & en;
      end
      assign irq = irq_q;
    end else begin : g_comb
      assign irq = pend_q & en;
    end
  endgenerate

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    set |=> pend_q); // R8
  AST_CLEAR_W1: assert property (@(posedge clk) disable iff (rst)
    (clr && !set) |=> !pend_q); // R8
endmodule

// File: rtl/line_state_detector.sv
module line_state_detector #(
  parameter int unsigned W    = 16,
  parameter int unsigned FRAC = 15,
  parameter int unsigned DBW  = lsd_pkg::LSD_DBW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp,
  input  logic                sel_ring,
  input  logic signed [W-1:0] coef_loop,
  input  logic signed [W-1:0] coef_ring,
  input  logic signed [W-1:0] thresh,
  input  logic                deb_load,
  input  logic [DBW-1:0]      deb_len,
  input  logic                irq_en,
  input  logic                irq_clr,
  output logic signed [W-1:0] filt_out,
  output logic                raw_det,
  output logic                det_status,
  output logic                irq_pending,
  output logic                irq
);
  import lsd_pkg::*;

  det_sel_e            sel;
  logic signed [W-1:0] coef_sel, y_nxt;
  logic                det_chg;

  assign sel      = det_sel_e'(sel_ring);
  assign coef_sel = (sel == SEL_RING) ? coef_ring : coef_loop;

  lsd_lowpass #(.W(W), .FRAC(FRAC)) u_lpf (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp(smp),
    .coef(coef_sel), .y_q(filt_out), .y_nxt(y_nxt)
  );

  lsd_debounce #(.W(W), .DBW(DBW), .DB_RST(LSD_DB_RESET)) u_deb (
    .clk(clk), .rst(rst), .step(smp_valid), .filt_nxt(y_nxt),
    .thresh(thresh), .deb_load(deb_load), .deb_len(deb_len),
    .raw_q(raw_det), .det_q(det_status), .det_chg(det_chg)
  );

  lsd_irq #(.REG_OUT(1'b0)) u_irq (
    .clk(clk), .rst(rst), .set(det_chg), .clr(irq_clr), .en(irq_en),
    .pend_q(irq_pending), .irq(irq)
  );

  AST_PEND_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (det_status != $past(det_status)) |-> irq_pending); // R8
  AST_RAW_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (rst)
    (raw_det != $past(raw_det)) |-> $past(smp_valid)); // R4
endmodule

// File: tb/line_state_detector_bench.sv
module line_state_detector_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_valid = 0, sel_ring = 0, deb_load = 0, irq_en = 0, irq_clr = 0;
  logic signed [15:0] smp = 0, coef_loop = 0, coef_ring = 0, thresh = 0;
  logic [6:0] deb_len = 0;
  logic signed [15:0] filt_out;
  logic raw_det, det_status, irq_pending, irq;

  int n_chk = 0, n_bad = 0;
  int m_y = 0, m_cnt = 0, m_len = 10;
  bit m_raw = 0, m_det = 0, m_pend = 0;
  bit done = 0;

  always #5ns clk = ~clk;

  line_state_detector u_line_state_detector (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp(smp), .sel_ring(sel_ring),
    .coef_loop(coef_loop), .coef_ring(coef_ring), .thresh(thresh),
    .deb_load(deb_load), .deb_len(deb_len), .irq_en(irq_en), .irq_clr(irq_clr),
    .filt_out(filt_out), .raw_det(raw_det), .det_status(det_status),
    .irq_pending(irq_pending), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int filt_step(int y, int x, int k);
    longint p;
    p = (longint'(x) - longint'(y)) * longint'(k);
    p = (p >>> 15) + longint'(y);
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  // one clock: advance model from current inputs, then compare at negedge
  task automatic tick();
    int  k, len;
    bit  cmp, chg;
    chg = 0;
    len = m_len;
    if (deb_load) m_len = int'(deb_len);
    if (smp_valid) begin
      k   = sel_ring ? int'(coef_ring) : int'(coef_loop);
      m_y = filt_step(m_y, int'(smp), k);
      cmp = (m_y > int'(thresh));
      m_raw = cmp;
      if (len == 0) len = 1;
      if (cmp == m_det) m_cnt = 0;
      else if (m_cnt + 1 >= len) begin m_det = cmp; m_cnt = 0; chg = 1; end
      else m_cnt++;
    end
    if (chg) m_pend = 1;
    else if (irq_clr) m_pend = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R2 filter", int'(filt_out), m_y);
    chk("R4 raw", int'(raw_det), int'(m_raw));
    chk("R6 debounce", int'(det_status), int'(m_det));
    chk("R8 pending", int'(irq_pending), int'(m_pend));
    chk("R9 irq", int'(irq), int'(m_pend & irq_en));
    deb_load = 0;
    irq_clr  = 0;
  endtask

  task automatic samples(input int x, input int n);
    for (int i = 0; i < n; i++) begin
      smp = 16'(x); smp_valid = 1; tick();
    end
  endtask

  initial begin
    #1_500_000ns;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int st;
    st = $urandom(32'd1234);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset filt", int'(filt_out), 0);
    chk("R1 reset det", int'(det_status), 0);
    chk("R1 reset irq", int'(irq_pending) + int'(irq) + int'(raw_det), 0);
    rst = 0;
    tick();

    // R3: ring coefficient 32767 on zero state gives 999, loop would give 250
    coef_ring = 16'sd32767; coef_loop = 16'sd8192; sel_ring = 1; thresh = 16'sd30000;
    samples(1000, 1);
    chk("R3 ring coef", int'(filt_out), 999);
    sel_ring = 0; samples(1999, 1);
    chk("R3 loop coef", int'(filt_out), 999 + 250);

    // R5: idle strobe keeps state
    smp_valid = 0; smp = 16'sd20000; tick(); tick();
    chk("R5 idle filt", int'(filt_out), 1249);

    // R7: default length 10 after reset
    irq_en = 1; thresh = 0; coef_loop = 16'sd32767;
    samples(20000, 9);
    chk("R7 default len 9", int'(det_status), 0);
    samples(20000, 1);
    chk("R7 default len 10", int'(det_status), 1);
    irq_clr = 1; smp_valid = 0; tick();

    // R6: length 3 with a glitch restarting the count
    deb_len = 7'd3; deb_load = 1; tick();
    samples(-20000, 2); samples(20000, 1); samples(-20000, 2);
    chk("R6 restart", int'(det_status), 1);
    samples(-20000, 1);
    chk("R6 len3", int'(det_status), 0);

    // R6: length 0 acts as 1; R8 set wins over clear
    deb_len = 0; deb_load = 1; tick();
    irq_clr = 1; samples(20000, 1);
    chk("R8 set wins", int'(irq_pending), 1);
    irq_en = 0; tick();
    chk("R9 masked", int'(irq), 0);

    // R2 saturation both ways
    coef_loop = 16'sd32767; samples(30000, 4);
    coef_loop = -16'sd32768; samples(-30000, 1);
    chk("R2 sat high", int'(filt_out), 32767);
    coef_loop = 16'sd32767; samples(-30000, 4);
    coef_loop = -16'sd32768; samples(30000, 1);
    chk("R2 sat low", int'(filt_out), -32768);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      smp_valid = ($urandom % 4) != 0;
      smp       = 16'($urandom);
      sel_ring  = $urandom % 2;
      if ($urandom % 16 == 0) coef_loop = 16'($urandom);
      if ($urandom % 16 == 0) coef_ring = 16'($urandom);
      if ($urandom % 32 == 0) thresh = 16'(int'($urandom % 4001) - 2000);
      if ($urandom % 64 == 0) begin deb_len = 7'($urandom % 6); deb_load = 1; end
      irq_clr = ($urandom % 8) == 0;
      irq_en  = ($urandom % 3) != 0;
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule